// File: doc/BRIEF.md
# Network Controller Interrupt Cause and Mask Unit

This block keeps the interrupt state of a network controller. Internal event sources, such as PHY-access completion, link change, descriptor write-back, transmit queue empty, receive overrun and receive minimum threshold, pulse one-cycle event lines. Each pulse latches a bit in a cause register. Software reaches the unit through a simple 32-bit register port with a 3-bit register select. Through that port it can set causes, clear causes with a write-1-to-clear write, or clear them all with one read. A mask register has separate set and clear addresses. The unit drives one level-sensitive interrupt line.

A cause-set shadow register always holds the same value as the cause register. Reading it does not clear anything. The top bit of the cause register is a summary bit. It is set whenever any lower cause bit is set, so software can test one bit to see whether anything is pending.

Top module: `nic_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after reset, the cause, shadow and mask registers are zero and `irq_o` is low.
- R2: A write to select 1 (cause-set) gives new cause bits [30:0] equal to the written data bits [30:0] ORed with the current bits [30:0].
- R3: A write to select 0 (cause) clears every cause bit in [30:0] whose data bit is 1, and leaves the other bits unchanged.
- R4: A write to select 2 ORs the data into the mask. A write to select 3 clears the mask bits whose data bit is 1.
- R5: `irq_o` is high exactly when the bitwise AND of the mask and cause registers is nonzero. Bit 31 of the mask therefore gates the summary bit.
- R6: A read of select 0 returns the current cause value on `reg_rdata_o` in the same cycle, and the cause register is zero from the next cycle on.
- R7: Cause bit 31 is 1 exactly when some cause bit in [30:0] is 1. Writing 1 to bit 31 alone creates no cause, and a fully cleared register reads zero.
- R8: A read of select 1 returns the shadow register, which always equals the cause register. The read has no side effect.
- R9: A pulse on `evt_i[k]` sets cause bit k. A pulse in the same cycle as a read-to-clear or a write-1-to-clear of that bit is kept.
- R10: Reads of select 2 and 3 return the mask. Selects 4 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Register select (0 cause, 1 cause-set, 2 mask-set, 3 mask-clear) |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, valid in the cycle of the read |
| evt_i | input | NUM_SRC | One-cycle event pulses; bit k sets cause bit k |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench builds the unit with its default values, DATA_W of 32 and NUM_SRC of 8. With these values the summary bit sits at bit 31 and event pulses reach cause bits 0 to 7. The bench can then fill every cause bit with one cause-set write and read it back as all ones. It can also set mask bit 31 alone, which exercises the case where the interrupt follows only the summary bit. It checks cycles where an event pulse lands on a read-to-clear or a write-1-to-clear, and writes to unused selects.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
    localparam int REG_SEL_W = 3;

    typedef enum logic [REG_SEL_W-1:0] {
        SEL_CAUSE     = 3'd0,
        SEL_CAUSE_SET = 3'd1,
        SEL_MASK_SET  = 3'd2,
        SEL_MASK_CLR  = 3'd3
    } reg_sel_e;
endpackage

// File: rtl/nic_irq_cause.sv
module nic_irq_cause #(
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = 8,
    localparam int LOW_W  = DATA_W - 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_clr_i,
    input  logic              w1c_en_i,
    input  logic              set_en_i,
    input  logic [LOW_W-1:0]  wdata_i,
    input  logic [NUM_SRC-1:0] evt_i,
    output logic [DATA_W-1:0] cause_o,
    output logic [DATA_W-1:0] shadow_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cause;
        logic [DATA_W-1:0] shadow;
    } cause_st_t;

    cause_st_t st_d, st_q;
    logic [LOW_W-1:0] evt_w;
    logic [LOW_W-1:0] low_d;

    assign evt_w = LOW_W'(evt_i);

    always_comb begin
        low_d = st_q.cause[LOW_W-1:0];
        if (rd_clr_i) low_d = '0;
        if (w1c_en_i) low_d = low_d & ~wdata_i;
        if (set_en_i) low_d = low_d | wdata_i;
        low_d = low_d | evt_w;           // events applied last: set wins
        st_d.cause  = (|low_d) ? {1'b1, low_d} : '0;
        st_d.shadow = st_d.cause;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cause_o  = st_q.cause;
    assign shadow_o = st_q.shadow;

    AST_SHADOW_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.shadow == st_q.cause); // R8
    AST_SUMMARY_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cause[DATA_W-1] == (|st_q.cause[LOW_W-1:0])); // R7
    AST_EVT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|evt_i) |=> ((st_q.cause[LOW_W-1:0] & $past(evt_w)) == $past(evt_w))); // R9
    AST_READ_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_clr_i && !set_en_i && evt_i == '0) |=> st_q.cause == '0); // R6
    AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (w1c_en_i && !set_en_i && evt_i == '0)
        |=> (st_q.cause[LOW_W-1:0] & $past(wdata_i)) == '0); // R3
endmodule

// File: rtl/nic_irq_mask.sv
module nic_irq_mask #(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              set_en_i,
    input  logic              clr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] mask_o
);
    typedef struct packed {
        logic [DATA_W-1:0] mask;
    } mask_st_t;

    mask_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_en_i) st_d.mask = st_d.mask & ~wdata_i;
        if (set_en_i) st_d.mask = st_d.mask | wdata_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign mask_o = st_q.mask;

    AST_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_en_i |=> (st_q.mask & $past(wdata_i)) == $past(wdata_i)); // R4
    AST_MASK_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_en_i && !set_en_i) |=> (st_q.mask & $past(wdata_i)) == '0); // R4
endmodule

// File: rtl/nic_irq_rdmux.sv
module nic_irq_rdmux
    import nic_irq_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [REG_SEL_W-1:0] sel_i,
    input  logic [DATA_W-1:0]    cause_i,
    input  logic [DATA_W-1:0]    shadow_i,
    input  logic [DATA_W-1:0]    mask_i,
    output logic [DATA_W-1:0]    rdata_o
);
    always_comb begin
        case (reg_sel_e'(sel_i))
            SEL_CAUSE:                  rdata_o = cause_i;
            SEL_CAUSE_SET:              rdata_o = shadow_i;
            SEL_MASK_SET, SEL_MASK_CLR: rdata_o = mask_i;
            default:                    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
    import nic_irq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_SRC = 8
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 reg_wr_i,
    input  logic                 reg_rd_i,
    input  logic [REG_SEL_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    input  logic [NUM_SRC-1:0]   evt_i,
    output logic                 irq_o
);
    localparam int LOW_W = DATA_W - 1;

    logic rd_clr, w1c_en, cset_en, mset_en, mclr_en;
    logic [DATA_W-1:0] cause_q, shadow_q, mask_q;

    always_comb begin
        rd_clr  = reg_rd_i && (reg_addr_i == SEL_CAUSE);
        w1c_en  = reg_wr_i && (reg_addr_i == SEL_CAUSE);
        cset_en = reg_wr_i && (reg_addr_i == SEL_CAUSE_SET);
        mset_en = reg_wr_i && (reg_addr_i == SEL_MASK_SET);
        mclr_en = reg_wr_i && (reg_addr_i == SEL_MASK_CLR);
    end

    nic_irq_cause #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_cause (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .rd_clr_i (rd_clr),
        .w1c_en_i (w1c_en),
        .set_en_i (cset_en),
        .wdata_i  (reg_wdata_i[LOW_W-1:0]),
        .evt_i    (evt_i),
        .cause_o  (cause_q),
        .shadow_o (shadow_q)
    );

    nic_irq_mask #(.DATA_W(DATA_W)) u_mask (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_en_i (mset_en),
        .clr_en_i (mclr_en),
        .wdata_i  (reg_wdata_i),
        .mask_o   (mask_q)
    );

    nic_irq_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .sel_i    (reg_addr_i),
        .cause_i  (cause_q),
        .shadow_i (shadow_q),
        .mask_i   (mask_q),
        .rdata_o  (reg_rdata_o)
    );

    assign irq_o = |(mask_q & cause_q);

    AST_IRQ_DROPS_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_clr && !reg_wr_i && evt_i == '0) |=> !irq_o); // R5
    AST_IDLE_SELECT_NO_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_clr && !w1c_en && !cset_en && !mset_en && !mclr_en && evt_i == '0)
        |=> ($stable(cause_q) && $stable(mask_q))); // R10
    AST_NO_IRQ_UNMASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_q == '0) |-> !irq_o); // R5
endmodule

// File: tb/test_nic_irq_ctrl.sv
module test_nic_irq_ctrl;
    localparam int DATA_W  = 32;
    localparam int NUM_SRC = 8;

    logic              clk = 1'b0;
    logic              rst_ni = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [NUM_SRC-1:0] evt = '0;
    logic              irq;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    nic_irq_ctrl #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) i_nic_irq_ctrl (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_addr_i  (reg_addr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .evt_i       (evt),
        .irq_o       (irq)
    );

    typedef struct packed {
        logic        wr;
        logic        rd;
        logic [2:0]  addr;
        logic [31:0] wdata;
        logic [7:0]  evt;
        logic        chk_rd;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 23;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0,1'b1,3'd0,32'h0,        8'h00,1'b1,32'h0,        1'b0,4'd6 },  // R6 read empty
        '{1'b1,1'b0,3'd1,32'h00000005, 8'h00,1'b0,32'h0,        1'b0,4'd2 },  // R2 set bits 0,2
        '{1'b0,1'b1,3'd1,32'h0,        8'h00,1'b1,32'h80000005, 1'b0,4'd8 },  // R8 R7 shadow
        '{1'b1,1'b0,3'd2,32'h00000004, 8'h00,1'b0,32'h0,        1'b1,4'd5 },  // R4 R5 unmask bit 2
        '{1'b0,1'b1,3'd2,32'h0,        8'h00,1'b1,32'h00000004, 1'b1,4'd10},  // R10 mask read
        '{1'b1,1'b0,3'd0,32'h00000004, 8'h00,1'b0,32'h0,        1'b0,4'd3 },  // R3 w1c bit 2
        '{1'b0,1'b1,3'd0,32'h0,        8'h00,1'b1,32'h80000001, 1'b0,4'd6 },  // R6 read-clear
        '{1'b0,1'b1,3'd0,32'h0,        8'h00,1'b1,32'h0,        1'b0,4'd6 },  // R6 now zero
        '{1'b0,1'b0,3'd0,32'h0,        8'h04,1'b0,32'h0,        1'b1,4'd9 },  // R9 event bit 2
        '{1'b1,1'b0,3'd3,32'h00000004, 8'h00,1'b0,32'h0,        1'b0,4'd4 },  // R4 mask clear
        '{1'b0,1'b1,3'd3,32'h0,        8'h00,1'b1,32'h0,        1'b0,4'd10},  // R10 read sel 3
        '{1'b1,1'b0,3'd1,32'h80000000, 8'h00,1'b0,32'h0,        1'b0,4'd7 },  // R7 bit31 write alone
        '{1'b1,1'b0,3'd2,32'h80000000, 8'h00,1'b0,32'h0,        1'b1,4'd5 },  // R5 summary mask
        '{1'b0,1'b1,3'd0,32'h0,        8'h02,1'b1,32'h80000004, 1'b1,4'd9 },  // R9 event beats read
        '{1'b0,1'b1,3'd1,32'h0,        8'h00,1'b1,32'h80000002, 1'b1,4'd9 },  // R9 kept value
        '{1'b1,1'b0,3'd0,32'h00000002, 8'h02,1'b0,32'h0,        1'b1,4'd9 },  // R9 event beats w1c
        '{1'b1,1'b0,3'd0,32'h00000002, 8'h00,1'b0,32'h0,        1'b0,4'd3 },  // R3 full clear
        '{1'b0,1'b1,3'd1,32'h0,        8'h00,1'b1,32'h0,        1'b0,4'd7 },  // R7 reads zero
        '{1'b1,1'b0,3'd5,32'hFFFFFFFF, 8'h00,1'b0,32'h0,        1'b0,4'd10},  // R10 unused write
        '{1'b0,1'b1,3'd5,32'h0,        8'h00,1'b1,32'h0,        1'b0,4'd10},  // R10 unused read
        '{1'b0,1'b1,3'd2,32'h0,        8'h00,1'b1,32'h80000000, 1'b0,4'd10},  // R10 mask intact
        '{1'b1,1'b0,3'd1,32'h7FFFFFFF, 8'h00,1'b0,32'h0,        1'b1,4'd2 },  // R2 all bits
        '{1'b0,1'b1,3'd0,32'h0,        8'h00,1'b1,32'hFFFFFFFF, 1'b0,4'd6 }   // R6 full read-clear
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0; evt = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "irq in reset", 32'(irq), 32'h0);
        reg_addr = 3'd1; #1;
        check("R1", "shadow in reset", reg_rdata, 32'h0);
        reg_addr = 3'd0;
        rst_ni = 1'b1;

        foreach (VECS[i]) begin
            @(negedge clk);
            reg_wr = VECS[i].wr; reg_rd = VECS[i].rd; reg_addr = VECS[i].addr;
            reg_wdata = VECS[i].wdata; evt = VECS[i].evt;
            #1;
            if (VECS[i].chk_rd)
                check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d rdata", i),
                      reg_rdata, VECS[i].exp_rd);
            @(posedge clk); #1;
            idle_inputs();
            check($sformatf("R%0d", VECS[i].req), $sformatf("vec %0d irq", i),
                  32'(irq), 32'(VECS[i].exp_irq));
        end

        // Directed: build state, then reset in the middle of activity (R1)
        @(negedge clk); evt = 8'hFF;
        @(negedge clk); evt = '0; reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1;
        @(negedge clk); idle_inputs();
        check("R5", "irq with bit 0 unmasked", 32'(irq), 32'h1);
        reg_addr = 3'd1; #1;
        check("R9", "all eight events latched", reg_rdata, 32'h800000FF);
        rst_ni = 1'b0;
        repeat (2) @(negedge clk);
        check("R1", "irq after reset", 32'(irq), 32'h0);
        for (int a = 0; a < 4; a++) begin
            reg_addr = 3'(a); #1;
            check("R1", $sformatf("sel %0d after reset", a), reg_rdata, 32'h0);
        end
        reg_addr = '0;
        rst_ni = 1'b1;
        @(negedge clk);
        check("R1", "irq after reset release", 32'(irq), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule